// File: doc/BRIEF.md
# Two-Read One-Write Register File

This block holds the working registers of a small processor core: eight words of 32 bits, selected by 4-bit register identifiers. Two read ports work independently and without a clock: each data output follows its identifier input within the same cycle. One write port stores its data word into the selected register on the rising clock edge. Both reads and the write can happen in the same cycle.

Any identifier of 8 or above is a null identifier. A read port given a null identifier outputs zero. A write with a null identifier changes nothing. The block has no bypass. A read of the register being written returns the stored value until the edge, and the new value after it.

A synchronous reset clears every register. The block is not state-machine based. Its only state is the storage array, and the write path is a per-register enable decode built with generate.

Top module: `regfile_2r1w`

## Requirements
- R1: When rst is high at a rising clock edge, all eight registers become zero. From the next cycle every read with identifier 0 to 7 returns 0.
- R2: A read port with identifier 0 to 7 outputs that register's stored value in the same cycle, without waiting for a clock edge.
- R3: The two read ports are independent. Each may select any register, including the same register as the other port, in the same cycle.
- R4: When rst is low and the write identifier is 0 to 7, the register it selects takes the write data at the rising clock edge. No other register changes.
- R5: A write identifier of 8 to 15 (bit 3 set) changes no register at the clock edge.
- R6: A read identifier of 8 to 15 (bit 3 set) drives 32'h0 on that port's data output.
- R7: A read of the register being written returns the old value before the edge and the new value after the edge. There is no bypass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes and reset act on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| rd_a_id | input | 4 | Register identifier for read port A |
| rd_a_data | output | 32 | Read port A data, combinational |
| rd_b_id | input | 4 | Register identifier for read port B |
| rd_b_data | output | 32 | Read port B data, combinational |
| wr_id | input | 4 | Write identifier; 8 to 15 means no write |
| wr_data | input | 32 | Data word to store |

## Verification
On every cycle, the assertions check:
- zero data on null read identifiers;
- that a real write lands in its register on the edge;
- that every register not selected by the write identifier keeps its value;
- that a null write leaves all registers unchanged;
- that reset leaves the array cleared.

Only the bench's scenarios can show the following:
- read ports returning the right stored words for every identifier pair;
- the old value before the edge and the new value after it when a read and a write hit the same register;
- that null writes leave earlier stored values readable through the ports.

// File: rtl/regfile_pkg.sv
package regfile_pkg;
    localparam int unsigned DATA_W   = 32;
    localparam int unsigned NUM_REGS = 8;
    localparam int unsigned ID_W     = 4;
    localparam int unsigned IDX_W    = $clog2(NUM_REGS);
    typedef logic [DATA_W-1:0] word_t;
    typedef logic [ID_W-1:0]   reg_id_t;
endpackage

// File: rtl/regfile_wr_decode.sv
module regfile_wr_decode #(
    parameter int unsigned NUM_REGS = 8,
    parameter int unsigned ID_W     = 4
) (
    input  logic [ID_W-1:0]     id,
    output logic [NUM_REGS-1:0] wen
);
    always_comb begin
        wen = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (id == ID_W'(i)) wen[i] = 1'b1;
        end
    end

    // R5
    always_comb begin
        wr_onehot_chk: assert ($onehot0(wen));
    end
endmodule

// File: rtl/regfile_rd_port.sv
module regfile_rd_port #(
    parameter int unsigned NUM_REGS = 8,
    parameter int unsigned ID_W     = 4,
    parameter int unsigned DATA_W   = 32
) (
    input  logic [ID_W-1:0]                 id,
    input  logic [NUM_REGS-1:0][DATA_W-1:0] regs,
    output logic [DATA_W-1:0]               data
);
    always_comb begin
        data = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (id == ID_W'(i)) data = regs[i];
        end
    end
endmodule

// File: rtl/regfile_2r1w.sv
module regfile_2r1w
    import regfile_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [3:0]  rd_a_id,
    output logic [31:0] rd_a_data,
    input  logic [3:0]  rd_b_id,
    output logic [31:0] rd_b_data,
    input  logic [3:0]  wr_id,
    input  logic [31:0] wr_data
);
    logic [NUM_REGS-1:0][DATA_W-1:0] regs_q;
    logic [NUM_REGS-1:0]             wen;

    regfile_wr_decode #(.NUM_REGS(NUM_REGS), .ID_W(ID_W)) wdec_i (
        .id(wr_id), .wen(wen)
    );

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)         regs_q[g] <= '0;
            else if (wen[g]) regs_q[g] <= wr_data;
        end
    end

    regfile_rd_port #(.NUM_REGS(NUM_REGS), .ID_W(ID_W), .DATA_W(DATA_W)) rda_i (
        .id(rd_a_id), .regs(regs_q), .data(rd_a_data)
    );
    regfile_rd_port #(.NUM_REGS(NUM_REGS), .ID_W(ID_W), .DATA_W(DATA_W)) rdb_i (
        .id(rd_b_id), .regs(regs_q), .data(rd_b_data)
    );

    // R6
    null_rd_a_chk: assert property (@(posedge clk) rd_a_id[3] |-> rd_a_data == '0);
    // R6
    null_rd_b_chk: assert property (@(posedge clk) rd_b_id[3] |-> rd_b_data == '0);
    // R1
    rst_clear_chk: assert property (@(posedge clk) rst |=> regs_q == '0);
    // R5
    null_wr_chk: assert property (@(posedge clk) disable iff (rst)
        wr_id[3] |=> $stable(regs_q));

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_chk
        // R4
        wr_land_chk: assert property (@(posedge clk) disable iff (rst)
            (wr_id == ID_W'(g)) |=> regs_q[g] == $past(wr_data));
        // R4
        wr_other_chk: assert property (@(posedge clk) disable iff (rst)
            (wr_id != ID_W'(g)) |=> $stable(regs_q[g]));
    end
endmodule

// File: tb/regfile_2r1w_tb_top.sv
module regfile_2r1w_tb_top;
    logic        clk = 0;
    logic        rst;
    logic [3:0]  rd_a_id, rd_b_id, wr_id;
    logic [31:0] rd_a_data, rd_b_data, wr_data;
    logic [31:0] model [8];
    int checks = 0, failures = 0;

    always #10 clk = ~clk;

    regfile_2r1w dut_i (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] expv(input logic [3:0] id);
        return id[3] ? 32'h0 : model[id[2:0]];
    endfunction

    task automatic sweep_reads(input string req);
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                rd_a_id = a[3:0]; rd_b_id = b[3:0];
                #1;
                check(req, rd_a_data, expv(a[3:0]));
                check(req, rd_b_data, expv(b[3:0]));
            end
        end
    endtask

    task automatic do_write(input logic [3:0] id, input logic [31:0] d);
        wr_id = id; wr_data = d;
        @(posedge clk); #1;
        if (!id[3]) model[id[2:0]] = d;
        wr_id = 4'hF;
    endtask

    initial begin
        #150000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rd_a_id = 0; rd_b_id = 0; wr_id = 4'd3; wr_data = 32'hDEAD_BEEF;
        rst = 1;
        @(posedge clk); @(posedge clk); #1;
        rst = 0; wr_id = 4'hF;
        for (int i = 0; i < 8; i++) model[i] = 0;
        sweep_reads("R1");
        // R4 write every register with a computed pattern
        for (int i = 0; i < 8; i++) do_write(i[3:0], 32'h1111_1111 * (i + 1) ^ 32'hA5A5_0000);
        // R2 R3 R6 full identifier sweep
        sweep_reads("R2_R3_R6");
        // R5 null writes with every null id
        for (int i = 8; i < 16; i++) do_write(i[3:0], 32'hFFFF_0000 | i);
        sweep_reads("R5");
        // R7 same-register read during write
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            rd_a_id = i[3:0]; rd_b_id = i[3:0];
            wr_id = i[3:0]; wr_data = ~model[i] + i;
            #1;
            check("R7_old", rd_a_data, model[i]);
            check("R7_old", rd_b_data, model[i]);
            @(posedge clk); #1;
            model[i] = wr_data;
            wr_id = 4'hF;
            check("R7_new", rd_a_data, model[i]);
            check("R7_new", rd_b_data, model[i]);
        end
        sweep_reads("R4");
        // R1 reset after data
        rst = 1; @(posedge clk); #1; rst = 0;
        for (int i = 0; i < 8; i++) model[i] = 0;
        sweep_reads("R1_after");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule